// File: doc/BRIEF.md
# Programmable Video Raster Timing Generator

This block produces the timing skeleton of a video main stream in a single pixel clock domain. A horizontal counter walks the clocks of each line and a vertical counter walks the lines of each frame. From the two counts it derives a horizontal sync, a vertical sync, a data-enable marking active pixels, and a one-cycle start-of-frame pulse. The counts themselves also appear on the outputs. Each sync begins at count 0 of its axis. The active window is placed by a start offset measured from that leading edge, not by porch values. Each sync has its own programmable polarity.

All timing values arrive on plain configuration inputs. The block copies them into shadow registers only at the end of the last clock of the last line of a frame, so software may rewrite them at any time without tearing a frame. The first copy is taken just after reset. The reset input is asserted asynchronously and released through a two-stage synchronizer. All outputs are registered and change together, so the counts on the outputs always belong to the sync, enable and start-of-frame bits presented in the same cycle.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is applied, every output (counts, hsync, vsync, data-enable, start-of-frame) is 0.
- R2: The horizontal count on `hcount_o` steps by one each clock from 0 up to line total minus 1, then returns to 0. A line total of 0 or 1 keeps it at 0.
- R3: `vcount_o` advances by one only in the cycle after `hcount_o` shows its last value. It returns to 0 after frame total minus 1.
- R4: The internal horizontal sync is active while `hcount_o` is below the horizontal sync width, so it starts at count 0. A width of 0 gives no pulse.
- R5: The internal vertical sync is active for whole lines while `vcount_o` is below the vertical sync width, so it starts at line 0. A width of 0 gives no pulse.
- R6: `de_o` is 1 exactly when `hcount_o` lies in [h start, h start + h active) and `vcount_o` lies in [v start, v start + v active). The sums are taken one bit wider, so a window reaching past the total simply ends at the line or frame end.
- R7: `cfg_sync_pol` bit 0 controls hsync and bit 1 controls vsync. A 0 drives the sync pin high when active; a 1 inverts the pin.
- R8: `sof_o` is 1 for one cycle, in the cycle where `hcount_o` and `vcount_o` are both 0, and at no other time (unless both totals are 1 or less).
- R9: Changes on the configuration inputs during a frame have no effect on that frame. The following frame runs entirely with the values present at the last clock of the last line.
- R10: After reset is released, the outputs stay 0 for three clocks. On the fourth clock edge the outputs show counts (0,0) with `sof_o` = 1, using the configuration present when the counters start.
- R11: A sync width of 0 and an active width of 0 produce no sync pulse and no data-enable in any cycle of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_h_total | input | 16 | Clocks per line, blanking included |
| cfg_v_total | input | 16 | Lines per frame |
| cfg_h_sync_w | input | 15 | Horizontal sync width in clocks |
| cfg_v_sync_w | input | 15 | Vertical sync width in lines |
| cfg_h_start | input | 16 | Clocks from hsync leading edge to first active pixel |
| cfg_v_start | input | 16 | Lines from vsync leading edge to first active line |
| cfg_h_active | input | 16 | Active pixels per line |
| cfg_v_active | input | 16 | Active lines per frame |
| cfg_sync_pol | input | 2 | Bit 0 hsync, bit 1 vsync; 1 inverts the pin |
| hcount_o | output | 16 | Horizontal count of the presented cycle |
| vcount_o | output | 16 | Vertical count of the presented cycle |
| hsync_o | output | 1 | Horizontal sync pin level |
| vsync_o | output | 1 | Vertical sync pin level |
| de_o | output | 1 | Active-video enable |
| sof_o | output | 1 | One-cycle start-of-frame pulse |

## Verification
The hardest case to reach from the ports is a configuration write that lands inside a frame. The expected outcome is that the rest of the frame keeps the old geometry and the next frame switches cleanly to the new one. The bench aligns to a start-of-frame pulse and lets a few pixels pass. It then rewrites every configuration input, keeps checking the rest of that frame against the old model, and checks the whole following frame against the new one. Tiny frames keep this affordable. The same route covers degenerate values: zero sync widths, zero active width, and active windows that run past the totals.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int CNT_W  = 16;
  localparam int SYNC_W = 15;
  localparam int NUM_AX = 2;
  localparam int AX_H   = 0;
  localparam int AX_V   = 1;

  typedef struct packed {
    logic [CNT_W-1:0]  total;
    logic [SYNC_W-1:0] sync_w;
    logic [CNT_W-1:0]  start;
    logic [CNT_W-1:0]  active;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t        h;
    axis_cfg_t        v;
    logic [NUM_AX-1:0] pol;
  } timing_cfg_t;
endpackage

// File: rtl/raster_rst_sync.sv
module raster_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/raster_axis_ctr.sv
module raster_axis_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] total_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam int XW = W + 1;

  logic [W-1:0]  cnt_q;
  logic [W-1:0]  cnt_n;
  logic [XW-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + XW'(1);
  // a total of 0 or 1 makes every position the last one
  assign last_o  = (cnt_inc >= {1'b0, total_i});

  always_comb begin
    cnt_n = cnt_q;
    if (en_i) begin
      if (last_o) cnt_n = '0;
      else        cnt_n = cnt_inc[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/raster_span.sv
module raster_span #(
  parameter int W  = 16,
  parameter int LW = 16
) (
  input  logic [W-1:0]  cnt_i,
  input  logic [W-1:0]  lo_i,
  input  logic [LW-1:0] len_i,
  output logic          in_o
);
  localparam int XW = W + 1;

  logic [XW-1:0] hi_x;

  // one extra bit so a window reaching past the counter range never wraps
  assign hi_x = {1'b0, lo_i} + XW'(len_i);
  assign in_o = (cnt_i >= lo_i) && ({1'b0, cnt_i} < hi_x);
endmodule

// File: rtl/raster_shadow.sv
module raster_shadow
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  timing_cfg_t cfg_i,
  output timing_cfg_t shadow_o
);
  timing_cfg_t sh_q;
  timing_cfg_t sh_n;

  always_comb begin
    sh_n = sh_q;
    if (load_i) sh_n = cfg_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign shadow_o = sh_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_h_total,
  input  logic [CNT_W-1:0]  cfg_v_total,
  input  logic [SYNC_W-1:0] cfg_h_sync_w,
  input  logic [SYNC_W-1:0] cfg_v_sync_w,
  input  logic [CNT_W-1:0]  cfg_h_start,
  input  logic [CNT_W-1:0]  cfg_v_start,
  input  logic [CNT_W-1:0]  cfg_h_active,
  input  logic [CNT_W-1:0]  cfg_v_active,
  input  logic [NUM_AX-1:0] cfg_sync_pol,
  output logic [CNT_W-1:0]  hcount_o,
  output logic [CNT_W-1:0]  vcount_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              sof_o
);
  logic        rst_ns;
  logic        live_q;
  logic        live_n;
  logic        frame_end;
  logic        shadow_load;
  timing_cfg_t cfg_in;
  timing_cfg_t shadow_q;

  axis_cfg_t         ax_cfg  [NUM_AX];
  logic [CNT_W-1:0]  ax_cnt  [NUM_AX];
  logic [NUM_AX-1:0] ax_last;
  logic [NUM_AX-1:0] ax_en;
  logic [NUM_AX-1:0] ax_sync;
  logic [NUM_AX-1:0] ax_act;

  logic [CNT_W-1:0] hcount_q, hcount_n;
  logic [CNT_W-1:0] vcount_q, vcount_n;
  logic             hsync_q, hsync_n;
  logic             vsync_q, vsync_n;
  logic             de_q, de_n;
  logic             sof_q, sof_n;

  raster_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign cfg_in.h.total  = cfg_h_total;
  assign cfg_in.h.sync_w = cfg_h_sync_w;
  assign cfg_in.h.start  = cfg_h_start;
  assign cfg_in.h.active = cfg_h_active;
  assign cfg_in.v.total  = cfg_v_total;
  assign cfg_in.v.sync_w = cfg_v_sync_w;
  assign cfg_in.v.start  = cfg_v_start;
  assign cfg_in.v.active = cfg_v_active;
  assign cfg_in.pol      = cfg_sync_pol;

  // live goes high one cycle after reset release; that first cycle primes the shadow
  assign live_n      = 1'b1;
  assign frame_end   = live_q & ax_last[AX_H] & ax_last[AX_V];
  assign shadow_load = ~live_q | frame_end;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) live_q <= 1'b0;
    else         live_q <= live_n;
  end

  raster_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load_i   (shadow_load),
    .cfg_i    (cfg_in),
    .shadow_o (shadow_q)
  );

  assign ax_cfg[AX_H] = shadow_q.h;
  assign ax_cfg[AX_V] = shadow_q.v;
  assign ax_en[AX_H]  = live_q;
  assign ax_en[AX_V]  = live_q & ax_last[AX_H];

  for (genvar a = 0; a < NUM_AX; a++) begin : g_axis
    raster_axis_ctr #(.W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_ns),
      .en_i    (ax_en[a]),
      .total_i (ax_cfg[a].total),
      .cnt_o   (ax_cnt[a]),
      .last_o  (ax_last[a])
    );

    raster_span #(.W(CNT_W), .LW(SYNC_W)) u_sync_span (
      .cnt_i (ax_cnt[a]),
      .lo_i  ('0),
      .len_i (ax_cfg[a].sync_w),
      .in_o  (ax_sync[a])
    );

    raster_span #(.W(CNT_W), .LW(CNT_W)) u_act_span (
      .cnt_i (ax_cnt[a]),
      .lo_i  (ax_cfg[a].start),
      .len_i (ax_cfg[a].active),
      .in_o  (ax_act[a])
    );
  end

  // output stage: next-state
  always_comb begin
    hcount_n = ax_cnt[AX_H];
    vcount_n = ax_cnt[AX_V];
    hsync_n  = 1'b0;
    vsync_n  = 1'b0;
    de_n     = 1'b0;
    sof_n    = 1'b0;
    if (live_q) begin
      hsync_n = ax_sync[AX_H] ^ shadow_q.pol[AX_H];
      vsync_n = ax_sync[AX_V] ^ shadow_q.pol[AX_V];
      de_n    = &ax_act;
      sof_n   = (ax_cnt[AX_H] == '0) && (ax_cnt[AX_V] == '0);
    end
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hcount_q <= '0;
      vcount_q <= '0;
      hsync_q  <= 1'b0;
      vsync_q  <= 1'b0;
      de_q     <= 1'b0;
      sof_q    <= 1'b0;
    end else begin
      hcount_q <= hcount_n;
      vcount_q <= vcount_n;
      hsync_q  <= hsync_n;
      vsync_q  <= vsync_n;
      de_q     <= de_n;
      sof_q    <= sof_n;
    end
  end

  assign hcount_o = hcount_q;
  assign vcount_o = vcount_q;
  assign hsync_o  = hsync_q;
  assign vsync_o  = vsync_q;
  assign de_o     = de_q;
  assign sof_o    = sof_q;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              live_i,
  input logic              frame_end_i,
  input timing_cfg_t       shadow_i,
  input logic [CNT_W-1:0]  h_int_i,
  input logic [CNT_W-1:0]  hcount_o,
  input logic [CNT_W-1:0]  vcount_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              de_o,
  input logic              sof_o
);
  timing_cfg_t sh_d;
  logic        live_d;
  logic        seen_q;

  // shadow and live delayed to line up with the registered output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_d   <= '0;
      live_d <= 1'b0;
    end else begin
      sh_d   <= shadow_i;
      live_d <= live_i;
    end
  end

  always_ff @(posedge clk) seen_q <= 1'b1;

  always @(posedge clk) begin
    if (!rst_n && seen_q) begin
      assert_reset_quiet_R1: assert ((hcount_o == '0) && (vcount_o == '0) && !hsync_o &&
                                     !vsync_o && !de_o && !sof_o)
        else $error("R1 outputs not cleared in reset");
    end
  end

  assert_hcount_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && (({1'b0, h_int_i} + 17'd1) < {1'b0, shadow_i.h.total}))
    |=> (h_int_i == $past(h_int_i) + 16'd1));

  assert_hcount_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_d && (sh_d.h.total != '0)) |-> (hcount_o < sh_d.h.total));

  assert_vcount_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_d && $past(live_d) && (hcount_o != '0)) |-> (vcount_o == $past(vcount_o)));

  assert_vcount_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (live_d && (sh_d.v.total != '0)) |-> (vcount_o < sh_d.v.total));

  assert_hsync_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_d && !sh_d.pol[AX_H] && (hcount_o >= {1'b0, sh_d.h.sync_w})) |-> !hsync_o);

  assert_vsync_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_d && !sh_d.pol[AX_V] && (vcount_o >= {1'b0, sh_d.v.sync_w})) |-> !vsync_o);

  assert_de_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> ((hcount_o >= sh_d.h.start) && (vcount_o >= sh_d.v.start) &&
              ({1'b0, hcount_o} < ({1'b0, sh_d.h.start} + {1'b0, sh_d.h.active})) &&
              ({1'b0, vcount_o} < ({1'b0, sh_d.v.start} + {1'b0, sh_d.v.active}))));

  assert_vsync_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_d && sh_d.pol[AX_V] && (vcount_o < {1'b0, sh_d.v.sync_w})) |-> !vsync_o);

  assert_sof_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> ((hcount_o == '0) && (vcount_o == '0)));

  assert_sof_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_o && (sh_d.h.total > 16'd1)) |=> !sof_o);

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !frame_end_i) |=> $stable(shadow_i));
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_ns),
  .live_i      (live_q),
  .frame_end_i (frame_end),
  .shadow_i    (shadow_q),
  .h_int_i     (ax_cnt[0]),
  .hcount_o    (hcount_o),
  .vcount_o    (vcount_o),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .sof_o       (sof_o)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  typedef struct {
    int ht; int vt; int hsw; int vsw;
    int hs; int vs; int ha; int va; int pol;
  } tcfg_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] cfg_h_total, cfg_v_total, cfg_h_start, cfg_v_start;
  logic [15:0] cfg_h_active, cfg_v_active;
  logic [14:0] cfg_h_sync_w, cfg_v_sync_w;
  logic [1:0]  cfg_sync_pol;
  logic [15:0] hcount_o, vcount_o;
  logic        hsync_o, vsync_o, de_o, sof_o;

  int  n_checks;
  int  n_fail;
  bit  done;

  tcfg_t cfg_a, cfg_b, cfg_c, cfg_z;

  raster_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total(cfg_h_total), .cfg_v_total(cfg_v_total),
    .cfg_h_sync_w(cfg_h_sync_w), .cfg_v_sync_w(cfg_v_sync_w),
    .cfg_h_start(cfg_h_start), .cfg_v_start(cfg_v_start),
    .cfg_h_active(cfg_h_active), .cfg_v_active(cfg_v_active),
    .cfg_sync_pol(cfg_sync_pol),
    .hcount_o(hcount_o), .vcount_o(vcount_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .sof_o(sof_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input tcfg_t c);
    cfg_h_total  = 16'(c.ht);
    cfg_v_total  = 16'(c.vt);
    cfg_h_sync_w = 15'(c.hsw);
    cfg_v_sync_w = 15'(c.vsw);
    cfg_h_start  = 16'(c.hs);
    cfg_v_start  = 16'(c.vs);
    cfg_h_active = 16'(c.ha);
    cfg_v_active = 16'(c.va);
    cfg_sync_pol = 2'(c.pol);
  endtask

  // Checks one full frame cycle by cycle, starting at a sampled sof.
  // At cycle chg_at the inputs are rewritten with nxt (R9): no effect expected here.
  task automatic check_frame(input tcfg_t c, input int chg_at, input tcfg_t nxt,
                             output int hs_cnt, output int de_cnt);
    int ht = (c.ht < 1) ? 1 : c.ht;
    int vt = (c.vt < 1) ? 1 : c.vt;
    int cyc = 0;
    hs_cnt = 0;
    de_cnt = 0;
    for (int v = 0; v < vt; v++) begin
      for (int h = 0; h < ht; h++) begin
        bit e_hs  = (h < c.hsw);
        bit e_vs  = (v < c.vsw);
        bit e_de  = (h >= c.hs) && (h < c.hs + c.ha) && (v >= c.vs) && (v < c.vs + c.va);
        bit e_sof = (h == 0) && (v == 0);
        chk((hcount_o == 16'(h)) && (vcount_o == 16'(v)), "R2/R3 counts",
            {hcount_o, vcount_o}, {16'(h), 16'(v)});
        chk(hsync_o == (e_hs ^ c.pol[0]), "R4/R7 hsync", 32'(hsync_o),
            32'(e_hs ^ c.pol[0]));
        chk(vsync_o == (e_vs ^ c.pol[1]), "R5/R7 vsync", 32'(vsync_o),
            32'(e_vs ^ c.pol[1]));
        chk(de_o == e_de, "R6 data enable", 32'(de_o), 32'(e_de));
        chk(sof_o == e_sof, "R8 start of frame", 32'(sof_o), 32'(e_sof));
        if (e_hs) hs_cnt++;
        if (de_o) de_cnt++;
        if (cyc == chg_at) apply(nxt);
        cyc++;
        @(negedge clk);
      end
    end
    chk(sof_o == 1'b1, "R9 next frame start", 32'(sof_o), 32'd1);
  endtask

  task automatic t_reset_startup();
    rst_n = 1'b1;
    apply(cfg_a);
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({hcount_o, vcount_o, hsync_o, vsync_o, de_o, sof_o} == '0, "R1 reset outputs",
        {hcount_o, vcount_o}, 32'd0);
    chk({hsync_o, vsync_o, de_o, sof_o} == 4'b0, "R1 reset flags",
        32'({hsync_o, vsync_o, de_o, sof_o}), 32'd0);
    rst_n = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(sof_o == 1'b0 && hsync_o == 1'b0 && de_o == 1'b0, "R10 quiet after release",
          32'({sof_o, hsync_o, de_o}), 32'd0);
    end
    @(negedge clk);
    chk(sof_o == 1'b1 && hcount_o == 16'd0 && vcount_o == 16'd0, "R10 first frame start",
        32'({sof_o, hcount_o[0], vcount_o[0]}), 32'd4);
  endtask

  task automatic t_basic();
    int hc, dc;
    check_frame(cfg_a, -1, cfg_a, hc, dc);
    chk(dc == cfg_a.ha * cfg_a.va, "R6 active pixel total", 32'(dc),
        32'(cfg_a.ha * cfg_a.va));
    check_frame(cfg_a, -1, cfg_a, hc, dc);
    chk(hc == cfg_a.hsw * cfg_a.vt, "R4 hsync clocks per frame", 32'(hc),
        32'(cfg_a.hsw * cfg_a.vt));
  endtask

  task automatic t_polarity();
    int hc, dc;
    check_frame(cfg_a, 3, cfg_b, hc, dc);
    check_frame(cfg_b, -1, cfg_b, hc, dc);
  endtask

  task automatic t_midframe();
    int hc, dc;
    check_frame(cfg_b, 10, cfg_c, hc, dc);
    check_frame(cfg_c, -1, cfg_c, hc, dc);
    chk(dc == 4 * (cfg_c.vt - cfg_c.vs), "R6 window clipped at totals", 32'(dc),
        32'(4 * (cfg_c.vt - cfg_c.vs)));
  endtask

  task automatic t_zero();
    int hc, dc;
    check_frame(cfg_c, 0, cfg_z, hc, dc);
    check_frame(cfg_z, -1, cfg_z, hc, dc);
    chk(hc == 0, "R11 no hsync pulse", 32'(hc), 32'd0);
    chk(dc == 0, "R11 no data enable", 32'(dc), 32'd0);
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    cfg_a = '{ht:12, vt:8, hsw:2, vsw:1, hs:4, vs:2, ha:6, va:4, pol:0};
    cfg_b = '{ht:9,  vt:6, hsw:3, vsw:2, hs:3, vs:2, ha:5, va:3, pol:3};
    cfg_c = '{ht:10, vt:5, hsw:1, vsw:3, hs:6, vs:1, ha:9, va:9, pol:1};
    cfg_z = '{ht:6,  vt:3, hsw:0, vsw:0, hs:0, vs:0, ha:0, va:3, pol:2};
    t_reset_startup();
    t_basic();
    t_polarity();
    t_midframe();
    t_zero();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule